// File: doc/BRIEF.md
# TLP ECRC Checker and Regenerator

This streaming unit sits on the forwarding path of a non-transparent bridge endpoint, directly after the stage that rewrites addresses and requester IDs in TLP headers. The header rewrite makes any end-to-end CRC that arrived with the TLP invalid for the outgoing copy. The unit therefore takes two word-aligned lanes in lock step, one DW per handshake. The received lane carries the TLP as it arrived. The translated lane carries the rewritten TLP. In a single pass the unit checks the received ECRC against a CRC taken over the received lane. It also computes a fresh CRC over the translated lane. It then emits the translated TLP with the TD bit and the trailing ECRC DW made consistent with the destination's generate setting. A one-cycle error pulse reports a failed check for logging elsewhere.

Control is a three-state machine. In IDLE the unit waits for a start word. In BODY it forwards words through a one-DW hold register. In FLUSH it drains the final data word and/or the appended ECRC while input is stalled. The transitions are:
- IDLE→BODY on acceptance of a start-of-TLP word.
- BODY→BODY on every middle word.
- BODY→IDLE on an end word that is a received ECRC while generation is off. The ECRC is dropped and the held word goes out as the last one.
- BODY→FLUSH on any other end word.
- FLUSH→FLUSH while the fresh ECRC is loaded behind the last data word.
- FLUSH→IDLE when the last word is pushed.

The check-enable, generate-enable and from-link inputs are sampled with the first DW and hold for the whole TLP. The output lags the input by one DW. That lag is what allows the word before a dropped ECRC to carry the end marker.

Top module: `ecrc_regen`

## Requirements
- R1: An ECRC is present in a received TLP exactly when bit 15 (TD) of the received first DW is 1. It is then the last DW of that TLP. It is never forwarded and never fed into the check CRC.
- R2: A check is made only when `cfg_chk_en` and `in_from_link`, sampled with the first DW, are both 1 and TD is 1. On a mismatch, `ecrc_err` is high for exactly one cycle: the cycle after the handshake of the TLP's last input DW.
- R3: A TLP whose received TD is 0 never raises `ecrc_err`, whatever the enables. Its translated words are forwarded unchanged apart from bit 15 of the first DW.
- R4: With `cfg_gen_en` = 1, bit 15 of the first output DW is 1. One extra DW follows the translated data as the last output word. It is the CRC computed over the translated lane.
- R5: With `cfg_gen_en` = 0, bit 15 of the first output DW is 0. No ECRC DW is emitted, so a TLP that arrived with an ECRC leaves one DW shorter.
- R6: Both CRCs use polynomial 0x04C11DB7 with the register seeded to all ones. Bytes are taken in the order bits 31:24, 23:16, 15:8, 7:0, and each byte least significant bit first. The ECRC DW is the complement of the final register, bit-reversed within each byte in place.
- R7: In both CRCs, bits 24 (lowest Type bit) and 14 (EP) of the first DW count as 1. For the generated CRC, bit 15 of the first DW also counts as 1.
- R8: A TLP whose received ECRC fails the check is still forwarded, and carries the freshly generated ECRC when generation is enabled.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output word and markers stay stable. No word is lost or repeated under any pattern of input gaps and output back-pressure.
- R10: The enables and `in_from_link` are used only as sampled with the first DW. Changes later in the TLP have no effect on it.
- R11: Each output TLP has `out_sop` on its first word only and `out_eop` on its last word only. A new TLP starts only after the previous one has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_chk_en | input | 1 | Check enable of the receiving endpoint |
| cfg_gen_en | input | 1 | Generate enable of the destination endpoint |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit accepts the input word |
| in_sop | input | 1 | First DW of a TLP |
| in_eop | input | 1 | Last DW of a TLP |
| in_from_link | input | 1 | TLP was received from this port's own link |
| in_rx_dw | input | 32 | Received (pre-translation) DW |
| in_tx_dw | input | 32 | Translated DW |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_sop | output | 1 | First DW of output TLP |
| out_eop | output | 1 | Last DW of output TLP |
| out_dw | output | 32 | Output DW |
| ecrc_err | output | 1 | One-cycle ECRC mismatch pulse |

## Verification
The check of a received ECRC and its replacement by the fresh CRC happen on the same input handshake. The error pulse and the loading of the appended DW therefore share a cycle. The bench provokes this by corrupting the received ECRC while generation is enabled, across every combination of the enables, from-link and TD, with input gaps and output stalls. It judges the case by counting exactly one pulse per failed check and requiring the appended DW to equal its own arithmetic CRC of the translated words. It also requires a dropped ECRC under stall to move the end marker onto the preceding word.

// File: rtl/ecrc_pkg.sv
`timescale 1ns/1ps
package ecrc_pkg;

    localparam int unsigned DW_BITS   = 32;
    localparam int unsigned BYTE_BITS = 8;
    localparam int unsigned DW_BYTES  = DW_BITS / BYTE_BITS;

    typedef logic [DW_BITS-1:0] dw_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BODY  = 2'd1,
        ST_FLUSH = 2'd2
    } regen_state_e;

    // Advance a CRC register over one DW: bytes high to low, each byte LSB first.
    function automatic dw_t crc_dw(input dw_t c, input dw_t d, input dw_t poly);
        dw_t  r;
        logic fb;
        r = c;
        for (int b = 0; b < DW_BYTES; b++) begin
            for (int i = 0; i < BYTE_BITS; i++) begin
                fb = r[DW_BITS-1] ^ d[DW_BITS - BYTE_BITS*(b+1) + i];
                r  = {r[DW_BITS-2:0], 1'b0} ^ (fb ? poly : '0);
            end
        end
        return r;
    endfunction

    // Complement and mirror each byte in place.
    function automatic dw_t crc_fin(input dw_t c);
        dw_t x;
        dw_t r;
        x = ~c;
        r = '0;
        for (int b = 0; b < DW_BYTES; b++) begin
            for (int i = 0; i < BYTE_BITS; i++) begin
                r[BYTE_BITS*b + i] = x[BYTE_BITS*b + BYTE_BITS - 1 - i];
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ecrc_lane.sv
`timescale 1ns/1ps
module ecrc_lane
    import ecrc_pkg::*;
#(
    parameter dw_t         POLY      = 32'h04C1_1DB7,
    parameter dw_t         SEED      = 32'hFFFF_FFFF,
    parameter int unsigned TD_BIT    = 15,
    parameter int unsigned EP_BIT    = 14,
    parameter int unsigned TYPE0_BIT = 24,
    parameter bit          FORCE_TD  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic feed,
    input  logic first,
    input  dw_t  dw,
    output dw_t  crc_q
);

    dw_t masked;

    always_comb begin
        masked = dw;
        if (first) begin
            masked[TYPE0_BIT] = 1'b1;
            masked[EP_BIT]    = 1'b1;
            if (FORCE_TD) begin
                masked[TD_BIT] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= SEED;
        end else if (feed) begin
            crc_q <= crc_dw(first ? SEED : crc_q, masked, POLY);
        end
    end

endmodule

// File: rtl/ecrc_out_stage.sv
`timescale 1ns/1ps
module ecrc_out_stage #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ld_dw,
    input  logic         ld_sop,
    input  logic         ld_eop,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [W-1:0] out_dw,
    output logic         out_sop,
    output logic         out_eop,
    output logic         can_load
);

    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_dw    <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else if (load) begin
            out_valid <= 1'b1;
            out_dw    <= ld_dw;
            out_sop   <= ld_sop;
            out_eop   <= ld_eop;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/ecrc_regen.sv
`timescale 1ns/1ps
module ecrc_regen
    import ecrc_pkg::*;
#(
    parameter dw_t         POLY      = 32'h04C1_1DB7,
    parameter dw_t         SEED      = 32'hFFFF_FFFF,
    parameter int unsigned TD_BIT    = 15,
    parameter int unsigned EP_BIT    = 14,
    parameter int unsigned TYPE0_BIT = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_chk_en,
    input  logic        cfg_gen_en,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic        in_from_link,
    input  logic [31:0] in_rx_dw,
    input  logic [31:0] in_tx_dw,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_sop,
    output logic        out_eop,
    output logic [31:0] out_dw,
    output logic        ecrc_err
);

    localparam int unsigned NUM_LANES = 2;
    localparam int unsigned LANE_CHK  = 0;
    localparam int unsigned LANE_GEN  = 1;

    regen_state_e state_q, state_d;

    dw_t  hold_dw;
    logic hold_sop, hold_last;
    logic gen_q, td_q, chk_q, err_q;

    logic can_push, acc, first_acc, body_acc, crc_word, feed;
    logic push, push_sop, push_eop;
    dw_t  push_dw, tx_fix, gen_fin, chk_fin;

    dw_t lane_dw  [NUM_LANES];
    dw_t lane_crc [NUM_LANES];

    // Handshake and word classification
    assign in_ready  = (state_q != ST_FLUSH) && can_push;
    assign acc       = in_valid && in_ready;
    assign first_acc = acc && (state_q == ST_IDLE) && in_sop;
    assign body_acc  = acc && (state_q == ST_BODY);
    assign crc_word  = body_acc && in_eop && td_q;
    assign feed      = first_acc || (body_acc && !crc_word);

    // Two CRC lanes: received stream for checking, translated stream for generation
    assign lane_dw[LANE_CHK] = in_rx_dw;
    assign lane_dw[LANE_GEN] = in_tx_dw;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        ecrc_lane #(
            .POLY      (POLY),
            .SEED      (SEED),
            .TD_BIT    (TD_BIT),
            .EP_BIT    (EP_BIT),
            .TYPE0_BIT (TYPE0_BIT),
            .FORCE_TD  (g == LANE_GEN)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .feed  (feed),
            .first (first_acc),
            .dw    (lane_dw[g]),
            .crc_q (lane_crc[g])
        );
    end

    assign gen_fin = crc_fin(lane_crc[LANE_GEN]);
    assign chk_fin = crc_fin(lane_crc[LANE_CHK]);

    always_comb begin
        tx_fix         = in_tx_dw;
        tx_fix[TD_BIT] = cfg_gen_en;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (first_acc) begin
                    state_d = ST_BODY;
                end
            end
            ST_BODY: begin
                if (body_acc && in_eop) begin
                    state_d = (crc_word && !gen_q) ? ST_IDLE : ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                if (can_push && hold_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output push decode
    always_comb begin
        push     = 1'b0;
        push_eop = 1'b0;
        push_dw  = hold_dw;
        push_sop = hold_sop;
        unique case (state_q)
            ST_IDLE: begin
                push = 1'b0;
            end
            ST_BODY: begin
                push     = body_acc;
                push_eop = crc_word && !gen_q;
            end
            ST_FLUSH: begin
                push     = can_push;
                push_eop = hold_last;
            end
            default: push = 1'b0;
        endcase
    end

    // Hold register, per-TLP sampled controls, error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_dw   <= '0;
            hold_sop  <= 1'b0;
            hold_last <= 1'b0;
            gen_q     <= 1'b0;
            td_q      <= 1'b0;
            chk_q     <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            err_q <= crc_word && chk_q && (in_rx_dw != chk_fin);
            if (first_acc) begin
                hold_dw   <= tx_fix;
                hold_sop  <= 1'b1;
                hold_last <= 1'b0;
                gen_q     <= cfg_gen_en;
                td_q      <= in_rx_dw[TD_BIT];
                chk_q     <= cfg_chk_en && in_from_link && in_rx_dw[TD_BIT];
            end else if (body_acc) begin
                hold_sop <= 1'b0;
                if (!in_eop) begin
                    hold_dw <= in_tx_dw;
                end else if (!td_q) begin
                    hold_dw   <= in_tx_dw;
                    hold_last <= !gen_q;
                end else if (gen_q) begin
                    hold_dw   <= gen_fin;
                    hold_last <= 1'b1;
                end
            end else if ((state_q == ST_FLUSH) && can_push && !hold_last) begin
                hold_dw   <= gen_fin;
                hold_sop  <= 1'b0;
                hold_last <= 1'b1;
            end
        end
    end

    assign ecrc_err = err_q;

    ecrc_out_stage #(
        .W (DW_BITS)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (push),
        .ld_dw     (push_dw),
        .ld_sop    (push_sop),
        .ld_eop    (push_eop),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_dw    (out_dw),
        .out_sop   (out_sop),
        .out_eop   (out_eop),
        .can_load  (can_push)
    );

endmodule

// File: rtl/ecrc_regen_chk.sv
`timescale 1ns/1ps
module ecrc_regen_chk #(
    parameter int unsigned TD_BIT = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_chk_en,
    input logic        cfg_gen_en,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_sop,
    input logic        in_eop,
    input logic        in_from_link,
    input logic [31:0] in_rx_dw,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_sop,
    input logic        out_eop,
    input logic [31:0] out_dw,
    input logic        ecrc_err
);

    logic in_open, out_open, g_last, rec_chk;
    logic in_hs, out_hs, in_first;

    assign in_hs    = in_valid && in_ready;
    assign out_hs   = out_valid && out_ready;
    assign in_first = in_hs && in_sop && !in_open;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_open  <= 1'b0;
            out_open <= 1'b0;
            g_last   <= 1'b0;
            rec_chk  <= 1'b0;
        end else begin
            if (in_hs) begin
                in_open <= in_open ? !in_eop : (in_sop && !in_eop);
            end
            if (out_hs) begin
                out_open <= out_open ? !out_eop : (out_sop && !out_eop);
            end
            if (in_first) begin
                g_last  <= cfg_gen_en;
                rec_chk <= cfg_chk_en && in_from_link && in_rx_dw[TD_BIT];
            end
        end
    end

    AST_TD_FOLLOWS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> (out_dw[TD_BIT] == g_last)); // R4 R5

    AST_ERR_NEEDS_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        ecrc_err |-> $past(in_hs && in_eop && in_open && rec_chk)); // R2 R3

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ecrc_err |=> !ecrc_err); // R2

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dw)
                                       && $stable(out_sop) && $stable(out_eop))); // R9

    AST_SOP_NOT_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hs && out_sop) |-> !out_open); // R11

    AST_BODY_IN_TLP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hs && !out_sop) |-> out_open); // R11

endmodule

bind ecrc_regen ecrc_regen_chk #(.TD_BIT(TD_BIT)) u_chk (.*);

// File: tb/ecrc_regen_test.sv
`timescale 1ns/1ps
module ecrc_regen_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_chk_en = 1'b0, cfg_gen_en = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_from_link = 1'b0;
    logic [31:0] in_rx_dw = '0, in_tx_dw = '0;
    logic        out_ready = 1'b1;
    logic        in_ready, out_valid, out_sop, out_eop, ecrc_err;
    logic [31:0] out_dw;

    always #2 clk = ~clk;   // 250 MHz

    ecrc_regen uut (
        .clk(clk), .rst_n(rst_n), .cfg_chk_en(cfg_chk_en), .cfg_gen_en(cfg_gen_en),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
        .in_from_link(in_from_link), .in_rx_dw(in_rx_dw), .in_tx_dw(in_tx_dw),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop),
        .out_eop(out_eop), .out_dw(out_dw), .ecrc_err(ecrc_err)
    );

    int checks = 0;
    int fails  = 0;
    int err_cnt = 0;
    logic [31:0] rng = 32'h1234_5678;

    logic [31:0] rx_w [0:7];
    logic [31:0] tx_w [0:7];
    logic [31:0] exp_w [0:7];
    logic [31:0] got [0:9];
    int          got_n;
    bit          fr_bad;

    always @(negedge clk) if (rst_n && ecrc_err) err_cnt++;

    task automatic rnd(output logic [31:0] v);
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        v = rng;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] tb_step(input logic [31:0] c, input logic [31:0] d);
        logic [31:0] r;
        r = c;
        for (int j = 0; j < 32; j++) begin
            logic b;
            b = d[24 - 8*(j/8) + (j%8)];
            if (r[31] ^ b) r = (r << 1) ^ 32'h04C1_1DB7;
            else           r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [31:0] tb_fin(input logic [31:0] c);
        logic [31:0] x, r;
        x = ~c;
        for (int k = 0; k < 32; k++) r[k] = x[(k/8)*8 + 7 - (k%8)];
        return r;
    endfunction

    function automatic logic [31:0] tb_mask(input logic [31:0] d, input bit td1);
        logic [31:0] r;
        r = d | 32'h0100_4000;
        if (td1) r[15] = 1'b1;
        return r;
    endfunction

    task automatic send(input int m, input int mode);
        int  i = 0;
        bit  scr = 0;
        logic [31:0] v;
        while (i < m) begin
            @(negedge clk);
            if (scr) begin
                cfg_chk_en   = ~cfg_chk_en;    // R10: late changes must not matter
                cfg_gen_en   = ~cfg_gen_en;
                in_from_link = ~in_from_link;
                scr = 0;
            end
            rnd(v);
            if (mode != 0 && v[3:2] == 2'b00) begin
                in_valid = 1'b0;
            end else begin
                in_valid = 1'b1;
                in_sop   = (i == 0);
                in_eop   = (i == m - 1);
                in_rx_dw = rx_w[i];
                in_tx_dw = tx_w[i];
                #1;
                if (in_ready) begin
                    if (i == 0) scr = 1;
                    i++;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic recv(input int mode);
        bit done = 0;
        logic [31:0] v;
        got_n  = 0;
        fr_bad = 0;
        while (!done) begin
            @(negedge clk);
            rnd(v);
            out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? v[0] : (v[1:0] == 2'b00);
            #2;
            if (out_valid && out_ready) begin
                if (got_n < 10) got[got_n] = out_dw;
                if (got_n == 0 && !out_sop) fr_bad = 1;
                if (got_n > 0 && out_sop)   fr_bad = 1;
                got_n++;
                if (out_eop) done = 1;
            end
        end
        @(negedge clk);
        out_ready = 1'b1;
    endtask

    task automatic run_one(input bit ce, input bit ge, input bit lk, input bit td,
                           input bit bad, input int n, input int mode);
        logic [31:0] v, c, ecrc, k1, k2;
        int m, en, e0;
        bit ok, exp_err;
        logic [31:0] bad_act, bad_exp;
        for (int i = 0; i < n; i++) begin
            rnd(v);
            rx_w[i] = v;
        end
        rx_w[0][15] = td;
        rnd(k1);
        rnd(k2);
        for (int i = 0; i < n; i++) tx_w[i] = rx_w[i];
        tx_w[1] = tx_w[1] ^ k1;
        tx_w[2] = tx_w[2] ^ k2;
        tx_w[0][24] = ~tx_w[0][24];   // R7: masked bits differ between lanes
        tx_w[0][14] = ~tx_w[0][14];
        tx_w[0][15] = k1[5];
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) c = tb_step(c, (i == 0) ? tb_mask(rx_w[0], 1'b0) : rx_w[i]);
        ecrc = tb_fin(c) ^ (bad ? 32'h0000_0010 : 32'h0);
        m = n + (td ? 1 : 0);
        if (td) begin
            rx_w[n] = ecrc;
            tx_w[n] = 32'hDEAD_BEEF;
        end
        for (int i = 0; i < n; i++) exp_w[i] = tx_w[i];
        exp_w[0][15] = ge;
        en = n + (ge ? 1 : 0);
        if (ge) begin
            c = 32'hFFFF_FFFF;
            for (int i = 0; i < n; i++) c = tb_step(c, (i == 0) ? tb_mask(tx_w[0], 1'b1) : tx_w[i]);
            exp_w[n] = tb_fin(c);
        end
        exp_err = ce && lk && td && bad;
        cfg_chk_en   = ce;
        cfg_gen_en   = ge;
        in_from_link = lk;
        e0 = err_cnt;
        fork
            send(m, mode);
            recv(mode);
        join
        repeat (3) @(negedge clk);
        chk(got_n == en, "R1 R4 R5 output length", got_n, en);
        chk(got[0] == exp_w[0], ge ? "R4 first DW with TD set" : "R5 first DW with TD cleared",
            got[0], exp_w[0]);
        ok = 1; bad_act = '0; bad_exp = '0;
        for (int i = 1; i < n; i++) begin
            if (ok && got[i] != exp_w[i]) begin
                ok = 0; bad_act = got[i]; bad_exp = exp_w[i];
            end
        end
        chk(ok, "R9 R10 translated payload", bad_act, bad_exp);
        if (ge) chk(got[n] == exp_w[n], bad ? "R8 R6 R7 regenerated ECRC after mismatch"
                                            : "R6 R7 appended ECRC", got[n], exp_w[n]);
        chk(!fr_bad, "R11 output framing", {31'd0, fr_bad}, 32'd0);
        chk((err_cnt - e0) == (exp_err ? 1 : 0), td ? "R2 error pulse count" : "R3 no error without TD",
            err_cnt - e0, exp_err ? 1 : 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid == 1'b0, "R11 reset out_valid", out_valid, 0);
        chk(ecrc_err == 1'b0, "R2 reset ecrc_err", ecrc_err, 0);
        chk(in_ready == 1'b1, "R9 reset in_ready", in_ready, 1);
        for (int mode = 0; mode < 3; mode++)
            for (int cf = 0; cf < 32; cf++)
                for (int pl = 0; pl < 4; pl++)
                    run_one(cf[0], cf[1], cf[2], cf[3], cf[4], 3 + pl, mode);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule